// File: doc/BRIEF.md
# Serial Master Frame Sequencer

This block is the transmit and receive engine of a synchronous serial master. When it is enabled and the transmit queue in front of it holds a word, it pops that word and opens a frame. Opening a frame means pulling an active-low select line down and turning on the data output driver. It then shifts the word out most significant bit first on a serial clock derived from the system clock. At the same time it shifts in the returning bit stream and hands each completed word to a receive queue.

The serial clock idles high. It starts each frame with a falling edge half a serial period after the select line drops. Output bits change on falling edges and input bits are taken on rising edges. If another word is queued when the last bit of a word is taken in, the next word follows with no gap and the select line stays low. Otherwise the select line rises one full serial period after that last rising edge. An end-of-transmission flag shows when the sequencer is idle and the transmit queue is empty. A sticky overrun flag records any received word that was dropped because the receive queue was full.

Top module: `spi_frame_seq`

## Requirements
- R1: During and right after reset: `fssN`=1, `sclk`=1, `sdoEn`=0, `txRd`=0, `rxWr`=0, `overrun`=0.
- R2: A frame opens only when `enable`=1 and `txEmpty`=0. `txRd` pulses for one system clock. `fssN` falls at the next clock edge. `sdoEn` equals the inverse of `fssN` at all times.
- R3: The first `sclk` transition of a frame is a falling edge. It occurs H system clocks after `fssN` falls, where H is the half-period length.
- R4: Each `sclk` half period lasts H system clocks, with H = `divN`. A `divN` value of 0 is treated as 1.
- R5: Words are sent MSB first. Each bit appears on `sdo` at a falling `sclk` edge and stays stable through the following rising edge.
- R6: `sdi` is taken on every rising `sclk` edge. On the last rising edge of a word, `rxWr` is high in the system clock that ends at that edge. In that same clock, `rxData` holds the WORD_W received bits, with the first-received bit in the MSB.
- R7: When no further word is sent, `fssN` returns high 2·H system clocks after the last rising `sclk` edge.
- R8: If `enable`=1 and `txEmpty`=0 in the clock of the last rising edge, the next word is popped in that same clock. `fssN` stays low, and the next word's MSB is launched H clocks later, keeping an unbroken clock pattern.
- R9: `eot` is 1 exactly when no frame is in progress and `txEmpty`=1. It is never 1 while `fssN` is low.
- R10: If `rxFull`=1 when a word completes, `rxWr` stays low, the word is dropped and `overrun` becomes 1. `overrun` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows new words to be started |
| divN | input | DIV_W | Half serial period in system clocks (0 acts as 1) |
| txEmpty | input | 1 | Transmit queue holds no word |
| txData | input | WORD_W | Head word of the transmit queue |
| txRd | output | 1 | Pop strobe for the transmit queue |
| rxFull | input | 1 | Receive queue cannot accept a word |
| rxWr | output | 1 | Push strobe for the receive queue |
| rxData | output | WORD_W | Received word, valid with `rxWr` |
| sclk | output | 1 | Serial clock, idle high |
| fssN | output | 1 | Active-low frame select |
| sdo | output | 1 | Serial data out |
| sdoEn | output | 1 | Output enable for `sdo` |
| sdi | input | 1 | Serial data in |
| eot | output | 1 | Idle with empty transmit queue |
| overrun | output | 1 | Sticky dropped-receive-word flag |

## Verification
The last rising edge of a word is where two functions coincide: pushing the received word and popping the next transmit word. The bench provokes this by queuing two words before enabling, with `sdi` looped back from `sdo`. It checks that `txRd` and `rxWr` are high in the same clock, that the select line stays low across the seam, and that every clock edge of both words keeps the H spacing. It also runs a frame with `rxFull` high, so the push is dropped. The pop and the received data are then judged separately through `rxWr`, `overrun` and a later frame.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_LEAD  = 2'd1,
    SEQ_SHIFT = 2'd2,
    SEQ_TRAIL = 2'd3
  } seqState_t;

  // Strobes from control to datapath, one system clock wide each.
  typedef struct packed {
    logic load;    // take txData into the transmit shifter
    logic launch;  // present next bit on sdo (falling sclk)
    logic sample;  // take sdi into the receive shifter (rising sclk)
    logic push;    // last rising edge of a word
  } ctlStrobes_t;

endpackage

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divN,
  input  logic             txEmpty,
  output logic             txRd,
  output ctlStrobes_t      strobes,
  output logic             sclk,
  output logic             fssN,
  output logic             eot
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  seqState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfLen;
  logic [CNT_W-1:0] bitCnt;
  logic             sclkReg;
  logic             fssReg;
  logic             trailHalf;
  logic             tick;
  logic             moreData;
  logic             startFrame;
  logic             lastRise;

  assign halfLen    = (divN == '0) ? DIV_W'(1) : divN;
  assign tick       = (divCnt >= halfLen - DIV_W'(1));
  assign moreData   = enable && !txEmpty;
  assign startFrame = (state == SEQ_IDLE) && moreData;
  assign lastRise   = (state == SEQ_SHIFT) && tick && !sclkReg && (bitCnt == '0);

  always_comb begin
    strobes.load   = startFrame || (lastRise && moreData);
    strobes.launch = tick && ((state == SEQ_LEAD) || ((state == SEQ_SHIFT) && sclkReg));
    strobes.sample = tick && (state == SEQ_SHIFT) && !sclkReg;
    strobes.push   = lastRise;
  end

  assign txRd = strobes.load;
  assign sclk = sclkReg;
  assign fssN = fssReg;
  assign eot  = (state == SEQ_IDLE) && txEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      divCnt    <= '0;
      bitCnt    <= '0;
      sclkReg   <= 1'b1;
      fssReg    <= 1'b1;
      trailHalf <= 1'b0;
    end else begin
      if (state == SEQ_IDLE) divCnt <= '0;
      else                   divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      case (state)
        SEQ_IDLE: if (startFrame) begin
          fssReg <= 1'b0;
          state  <= SEQ_LEAD;
        end
        SEQ_LEAD: if (tick) begin
          sclkReg <= 1'b0;
          bitCnt  <= LAST_BIT;
          state   <= SEQ_SHIFT;
        end
        SEQ_SHIFT: if (tick) begin
          if (sclkReg) begin
            sclkReg <= 1'b0;
          end else begin
            sclkReg <= 1'b1;
            if (bitCnt == '0) begin
              if (moreData) begin
                bitCnt <= LAST_BIT;
              end else begin
                trailHalf <= 1'b0;
                state     <= SEQ_TRAIL;
              end
            end else begin
              bitCnt <= bitCnt - CNT_W'(1);
            end
          end
        end
        SEQ_TRAIL: if (tick) begin
          if (trailHalf) begin
            fssReg <= 1'b1;
            state  <= SEQ_IDLE;
          end else begin
            trailHalf <= 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // The serial clock rests high whenever no frame is selected.
  assert_sclk_rests_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    fssN |-> sclk);

  // A pop is always followed by an asserted frame select.
  assert_pop_selects_R2: assert property (@(posedge clk) disable iff (!rstN)
    txRd |=> !fssN);

  // Frame select falls while the serial clock is still high.
  assert_lead_clock_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fssN) |-> sclk);

  // Frame select is released only after a high serial clock period.
  assert_release_clock_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fssN) |-> (sclk && $past(sclk)));

  // End of transmission never overlaps a selected frame.
  assert_eot_outside_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    eot |-> fssN);

endmodule

// File: rtl/spi_seq_datapath.sv
module spi_seq_datapath
  import spi_seq_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [WORD_W-1:0] txData,
  input  logic              sdi,
  input  logic              rxFull,
  output logic              sdo,
  output logic              rxWr,
  output logic [WORD_W-1:0] rxData,
  output logic              overrun
);

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic              sdoReg;
  logic              overrunReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift    <= '0;
      rxShift    <= '0;
      sdoReg     <= 1'b0;
      overrunReg <= 1'b0;
    end else begin
      if (strobes.load) begin
        txShift <= txData;
      end else if (strobes.launch) begin
        sdoReg  <= txShift[WORD_W-1];
        txShift <= {txShift[WORD_W-2:0], 1'b0};
      end
      if (strobes.sample) rxShift <= {rxShift[WORD_W-2:0], sdi};
      if (strobes.push && rxFull) overrunReg <= 1'b1;
    end
  end

  assign sdo     = sdoReg;
  assign rxData  = {rxShift[WORD_W-2:0], sdi};
  assign rxWr    = strobes.push && !rxFull;
  assign overrun = overrunReg;

  // Once raised, the overrun flag holds.
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // Overrun only rises after a completed word met a full queue.
  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxFull && strobes.push));

  // Serial output changes only at a launch.
  assert_sdo_moves_on_launch_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdo) |-> $past(strobes.launch));

endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_seq_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divN,
  input  logic              txEmpty,
  input  logic [WORD_W-1:0] txData,
  output logic              txRd,
  input  logic              rxFull,
  output logic              rxWr,
  output logic [WORD_W-1:0] rxData,
  output logic              sclk,
  output logic              fssN,
  output logic              sdo,
  output logic              sdoEn,
  input  logic              sdi,
  output logic              eot,
  output logic              overrun
);

  ctlStrobes_t strobes;

  spi_seq_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .divN(divN),
    .txEmpty(txEmpty), .txRd(txRd), .strobes(strobes),
    .sclk(sclk), .fssN(fssN), .eot(eot)
  );

  spi_seq_datapath #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txData(txData),
    .sdi(sdi), .rxFull(rxFull), .sdo(sdo), .rxWr(rxWr),
    .rxData(rxData), .overrun(overrun)
  );

  assign sdoEn = !fssN;

endmodule

// File: tb/spi_frame_seq_tb_top.sv
module spi_frame_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W     = 8;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [DIV_W-1:0] divN = DIV_W'(1);
  logic             txEmpty;
  logic [W-1:0]     txData;
  logic             txRd;
  logic             rxFull = 1'b0;
  logic             rxWr;
  logic [W-1:0]     rxData;
  logic             sclk, fssN, sdo, sdoEn, sdi, eot, overrun;
  logic             sdiInv = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_seq #(.WORD_W(W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .divN(divN),
    .txEmpty(txEmpty), .txData(txData), .txRd(txRd),
    .rxFull(rxFull), .rxWr(rxWr), .rxData(rxData),
    .sclk(sclk), .fssN(fssN), .sdo(sdo), .sdoEn(sdoEn),
    .sdi(sdi), .eot(eot), .overrun(overrun)
  );

  // Loopback slave, optionally inverting.
  assign sdi = sdo ^ sdiInv;

  // Bench transmit queue.
  logic [W-1:0] txMem [0:15];
  int txWrPtr = 0;
  int txRdPtr = 0;
  assign txEmpty = (txWrPtr == txRdPtr);
  assign txData  = txMem[txRdPtr % 16];
  always @(posedge clk) if (txRd && !txEmpty) txRdPtr <= txRdPtr + 1;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor, sampled at the falling system clock edge.
  int fssFallCyc, fssRiseCyc, fssRiseCount, edgeCount, txRdCount, rxWrCount;
  int txRdCyc [0:7];
  int rxWrCyc [0:7];
  logic [W-1:0] rxWords [0:7];
  int edgeCyc [0:63];
  logic edgeLvl [0:63];
  int sdoEnBad, eotInFrame;
  logic [31:0] capBits;
  logic prevSclk = 1'b1, prevFss = 1'b1;

  task automatic clearMon();
    fssFallCyc = -1; fssRiseCyc = -1; fssRiseCount = 0; edgeCount = 0;
    txRdCount = 0; rxWrCount = 0; sdoEnBad = 0; eotInFrame = 0; capBits = '0;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (prevFss && !fssN) fssFallCyc = cyc;
      if (!prevFss && fssN) begin fssRiseCyc = cyc; fssRiseCount++; end
      if (prevSclk != sclk) begin
        if (edgeCount < 64) begin edgeCyc[edgeCount] = cyc; edgeLvl[edgeCount] = sclk; end
        edgeCount++;
        if (sclk) capBits = {capBits[30:0], sdo};
      end
      if (txRd) begin if (txRdCount < 8) txRdCyc[txRdCount] = cyc; txRdCount++; end
      if (rxWr) begin
        if (rxWrCount < 8) begin rxWrCyc[rxWrCount] = cyc; rxWords[rxWrCount] = rxData; end
        rxWrCount++;
      end
      if (sdoEn != !fssN) sdoEnBad++;
      if (eot && !fssN) eotInFrame++;
    end
    prevSclk = sclk;
    prevFss  = fssN;
  end

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Queue nw words, enable, and wait for the frame to close.
  task automatic runFrames(input logic [DIV_W-1:0] d, input bit inv, input bit full,
                           input int nw, input logic [W-1:0] w0, input logic [W-1:0] w1);
    @(negedge clk);
    clearMon();
    divN = d; sdiInv = inv; rxFull = full;
    txMem[txWrPtr % 16] = w0; txWrPtr++;
    if (nw > 1) begin txMem[txWrPtr % 16] = w1; txWrPtr++; end
    enable = 1'b1;
    for (int i = 0; i < 5000 && fssRiseCount == 0; i++) @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Common timing and data checks for nw words at half period h.
  task automatic checkFrames(input int h, input int nw, input bit inv, input bit full,
                             input logic [W-1:0] w0, input logic [W-1:0] w1);
    int bad = 0;
    int lastRise;
    logic [2*W-1:0] expBits;
    chk(txRdCount == nw, "R2 pop count", txRdCount, nw);
    chk(fssFallCyc == txRdCyc[0] + 1, "R2 select falls after pop", fssFallCyc, txRdCyc[0] + 1);
    chk(sdoEnBad == 0, "R2 output enable tracks select", sdoEnBad, 0);
    chk(edgeCount == 2*W*nw, "R4 clock edge count", edgeCount, 2*W*nw);
    chk(edgeLvl[0] == 1'b0 && edgeCyc[0] == fssFallCyc + h, "R3 first edge falls after lead",
        edgeCyc[0], fssFallCyc + h);
    for (int k = 0; k < 2*W*nw && k < 64; k++)
      if (edgeCyc[k] != fssFallCyc + h*(k+1) || edgeLvl[k] != (k % 2 == 1)) bad++;
    chk(bad == 0, "R4 R8 edge spacing", bad, 0);
    expBits = (nw > 1) ? {w0, w1} : {{W{1'b0}}, w0};
    chk(capBits[2*W-1:0] == expBits, "R5 MSB-first serial bits", capBits[2*W-1:0], expBits);
    lastRise = fssFallCyc + 2*W*h;
    if (full) begin
      chk(rxWrCount == 0, "R10 no push when full", rxWrCount, 0);
      chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
    end else begin
      chk(rxWrCount == nw, "R6 push count", rxWrCount, nw);
      chk(rxWrCyc[0] == lastRise - 1, "R6 push on last rising edge", rxWrCyc[0], lastRise - 1);
      chk(rxWords[0] == (w0 ^ {W{inv}}), "R6 received word", rxWords[0], w0 ^ {W{inv}});
    end
    if (nw > 1) begin
      chk(txRdCyc[1] == lastRise - 1, "R8 next pop with last rise", txRdCyc[1], lastRise - 1);
      if (!full)
        chk(rxWords[1] == (w1 ^ {W{inv}}), "R8 second received word", rxWords[1], w1 ^ {W{inv}});
      lastRise = fssFallCyc + 4*W*h;
    end
    chk(fssRiseCount == 1, "R8 single select release", fssRiseCount, 1);
    chk(fssRiseCyc == lastRise + 2*h, "R7 select trails last rise", fssRiseCyc, lastRise + 2*h);
    chk(eotInFrame == 0, "R9 no eot during frame", eotInFrame, 0);
    chk(eot == 1'b1, "R9 eot when idle and empty", eot, 1);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(fssN == 1'b1 && sclk == 1'b1 && sdoEn == 1'b0, "R1 pins in reset", {fssN, sclk, sdoEn}, 3'b110);
    rstN = 1'b1;
    @(negedge clk);
    chk(txRd == 1'b0 && rxWr == 1'b0 && overrun == 1'b0, "R1 strobes after reset",
        {txRd, rxWr, overrun}, 0);
    chk(fssN == 1'b1 && sclk == 1'b1, "R1 idle pins after reset", {fssN, sclk}, 2'b11);
    chk(eot == 1'b1, "R9 eot idle empty", eot, 1);
  endtask

  task automatic testEnableGate();
    @(negedge clk);
    clearMon();
    txMem[txWrPtr % 16] = 8'h5A; txWrPtr++;
    repeat (40) @(negedge clk);
    chk(txRdCount == 0 && fssN == 1'b1, "R2 disabled holds off frame", txRdCount, 0);
    chk(eot == 1'b0, "R9 eot low with queued data", eot, 0);
    txWrPtr = txRdPtr;
    @(negedge clk);
  endtask

  task automatic testSingle(input int d, input bit inv, input logic [W-1:0] w);
    int h = (d == 0) ? 1 : d;
    runFrames(DIV_W'(d), inv, 1'b0, 1, w, '0);
    checkFrames(h, 1, inv, 1'b0, w, '0);
  endtask

  task automatic testBackToBack();
    runFrames(DIV_W'(2), 1'b0, 1'b0, 2, 8'hC3, 8'h3C);
    checkFrames(2, 2, 1'b0, 1'b0, 8'hC3, 8'h3C);
    chk(txRdCyc[1] == rxWrCyc[0], "R8 pop and push share a clock", txRdCyc[1], rxWrCyc[0]);
  endtask

  task automatic testOverrun();
    runFrames(DIV_W'(1), 1'b0, 1'b1, 1, 8'h81, '0);
    checkFrames(1, 1, 1'b0, 1'b1, 8'h81, '0);
    rxFull = 1'b0;
    runFrames(DIV_W'(1), 1'b0, 1'b0, 1, 8'h7E, '0);
    chk(rxWrCount == 1 && rxWords[0] == 8'h7E, "R10 later word accepted", rxWords[0], 8'h7E);
    chk(overrun == 1'b1, "R10 overrun stays set", overrun, 1);
  endtask

  initial begin
    clearMon();
    testReset();
    testEnableGate();
    testSingle(1, 1'b0, 8'hA5);
    testSingle(3, 1'b1, 8'h96);
    testSingle(0, 1'b0, 8'h01);
    testBackToBack();
    testOverrun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule